// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. One half takes 8-bit words from a parallel valid/ready handshake and shifts each one out on a single line as a framed character. The other half watches an incoming line, rebuilds characters from it, and presents each one with its error flags. Three static control inputs set the frame shape: whether a parity bit is present, whether that parity is even or odd, and whether one or two stop bits follow the data. These inputs must not change while a character is being sent or received.

A programmable divider creates a tick that both halves share. Each bit on the line lasts sixteen ticks. The receiver uses those ticks to oversample the line and takes each bit at its centre. It checks only the first stop bit. A low level in a configured second stop-bit slot is therefore not an error: it starts the next character. Each received word appears with a one-cycle valid pulse. The word and its flags then hold until the next word arrives. The consumer acknowledges a word with a take pulse, and a new word that arrives before the previous one was taken is marked as an overrun.

Top module: `serial_xcvr`

## Requirements
- R1: The divider produces one tick every `baud_div`+1 clock cycles. Every transmitted data bit lasts exactly 16 ticks, which is 16×(`baud_div`+1) cycles.
- R2: `tx_ready` is high only while the transmitter is idle, and the idle line level is 1. A word is loaded only on a cycle where `tx_valid` and `tx_ready` are both high. A `tx_valid` raised during a frame has no effect on the bits sent.
- R3: A transmitted frame is, in order: a start bit of 0, eight data bits least significant first, then a parity bit only if `par_en`=1, then one stop bit of 1 when `stop_two`=0 or two stop bits of 1 when `stop_two`=1. The transmitter returns to idle after the last stop bit.
- R4: The parity bit makes the number of ones across the data bits and the parity bit even when `par_odd`=0, and odd when `par_odd`=1. When `par_en`=0 no parity bit is sent, and `par_odd` changes nothing on either line.
- R5: A falling edge on `rxd` starts a character only if the line is still low 8 ticks later. A shorter low pulse is dropped and produces no `rx_valid`.
- R6: Received data bits are sampled at their centres, least significant first. Each character produces a single-cycle `rx_valid` pulse carrying `rx_data`.
- R7: When `par_en`=1, `rx_par_err` is 1 if the received data bits plus the received parity bit fail the polarity chosen by `par_odd`. When `par_en`=0, `rx_par_err` is 0.
- R8: `rx_frm_err` is 1 exactly when the first stop bit is sampled as 0.
- R9: The receiver never checks a second stop bit. With `stop_two`=1, a start bit sent in the second stop-bit slot is received as the next character, and the earlier character has no framing error.
- R10: `rx_overrun` is 1 with a new `rx_valid` when the previous word received no `rx_take` pulse. Otherwise it is 0.
- R11: `rx_data` and its three flags change only in the cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Tick period minus one, in clock cycles |
| par_en | input | 1 | 1 adds a parity bit and checks it |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| stop_two | input | 1 | 0 selects one stop bit, 1 selects two stop bits |
| tx_data | input | 8 | Word to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter is idle and will accept a word |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_take | input | 1 | Pulse that acknowledges the held received word |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle pulse for a new received word |
| rx_par_err | output | 1 | Parity failure for the held word |
| rx_frm_err | output | 1 | First stop bit was low for the held word |
| rx_overrun | output | 1 | The held word arrived before the previous one was taken |

## Verification
Some properties are checked on every cycle. These are: the idle line is high, an accepted word begins with a low start bit, the stop slots stay high, the parity state is skipped when parity is disabled, the valid pulse lasts one cycle, the received word and its flags stay stable, an unconfirmed start is dropped, and the divider never ticks twice in a row when the divisor is non-zero. Other behaviour can only be shown by the bench scenarios. These include the exact bit timing, the bit order, the computed parity values under every frame shape, the framing flag, the second-stop-bit start case and the overrun flag. The bench sweeps all eight combinations of the control inputs in both directions.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;
  localparam int DW  = 8;
  localparam int OVS = 16;
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(DW);

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_HUNT, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

  // parity bit that gives the requested total polarity (0 even, 1 odd)
  function automatic logic parity_bit(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // true when data plus parity bit do not reach the requested polarity
  function automatic logic parity_bad(input logic [DW-1:0] d, input logic p, input logic odd);
    return (^{d, p}) != odd;
  endfunction
endpackage

// File: rtl/serial_xcvr_baud.sv
module serial_xcvr_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (tick) cnt <= div;
    else          cnt <= cnt - 1'b1;
  end

  // R1: with a non-zero divisor, two consecutive ticks are impossible
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/serial_xcvr_tx.sv
module serial_xcvr_tx
  import serial_xcvr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop_two,
  input  logic [DW-1:0] din,
  input  logic          din_valid,
  output logic          din_ready,
  output logic          txd
);
  tx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          pbit;
  logic          second;
  logic          accept;
  logic          bit_end;

  assign din_ready = (st == TX_IDLE);
  assign accept    = din_valid && din_ready;
  assign bit_end   = tick && (tcnt == CW'(OVS-1)) && (st != TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_IDLE; tcnt <= '0; idx <= '0; sh <= '0;
      pbit <= 1'b0; second <= 1'b0; txd <= 1'b1;
    end else if (accept) begin
      sh   <= din;
      pbit <= parity_bit(din, par_odd);
      st   <= TX_START;
      tcnt <= '0;
      txd  <= 1'b0;
    end else if (st != TX_IDLE && tick) begin
      if (!bit_end) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (st)
          TX_START: begin
            st <= TX_DATA; idx <= '0; txd <= sh[0];
          end
          TX_DATA: begin
            if (idx == IW'(DW-1)) begin
              if (par_en) begin
                st <= TX_PAR; txd <= pbit;
              end else begin
                st <= TX_STOP; txd <= 1'b1; second <= 1'b0;
              end
            end else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
              txd <= sh[1];
            end
          end
          TX_PAR: begin
            st <= TX_STOP; txd <= 1'b1; second <= 1'b0;
          end
          TX_STOP: begin
            if (stop_two && !second) second <= 1'b1;
            else                     st <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  // R2: an idle transmitter holds the line high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> txd);
  // R3: an accepted word starts with a low start bit and drops ready
  p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd && !din_ready));
  // R3: every stop slot drives a high level
  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_STOP) |-> txd);
  // R4: without parity the parity slot is never entered
  p_no_par_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> (st != TX_PAR));
endmodule

// File: rtl/serial_xcvr_rx.sv
module serial_xcvr_rx
  import serial_xcvr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rxd,
  input  logic          take,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          perr,
  output logic          ferr,
  output logic          ovr
);
  logic          s1, s2;
  logic          line;
  rx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          pbit;
  logic          pend;
  logic          mid_hit;
  logic          bit_hit;
  logic          frame_done;

  assign line       = s2;
  assign mid_hit    = tick && (tcnt == CW'(OVS/2-1));
  assign bit_hit    = tick && (tcnt == CW'(OVS-1));
  assign frame_done = (st == RX_STOP) && bit_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; st <= RX_HUNT; tcnt <= '0; idx <= '0;
      sh <= '0; pbit <= 1'b0; pend <= 1'b0; dout <= '0;
      dout_valid <= 1'b0; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      dout_valid <= 1'b0;
      if (take) pend <= 1'b0;
      case (st)
        RX_HUNT: begin
          if (tick && !line) begin st <= RX_START; tcnt <= '0; end
        end
        RX_START: begin
          if (mid_hit) begin
            tcnt <= '0; idx <= '0;
            st   <= line ? RX_HUNT : RX_DATA;
          end else if (tick) tcnt <= tcnt + 1'b1;
        end
        RX_DATA: begin
          if (bit_hit) begin
            tcnt <= '0;
            sh   <= {line, sh[DW-1:1]};
            if (idx == IW'(DW-1)) st <= par_en ? RX_PAR : RX_STOP;
            else                  idx <= idx + 1'b1;
          end else if (tick) tcnt <= tcnt + 1'b1;
        end
        RX_PAR: begin
          if (bit_hit) begin
            tcnt <= '0; pbit <= line; st <= RX_STOP;
          end else if (tick) tcnt <= tcnt + 1'b1;
        end
        RX_STOP: begin
          if (bit_hit) begin
            tcnt       <= '0;
            st         <= RX_HUNT;
            dout       <= sh;
            dout_valid <= 1'b1;
            ferr       <= !line;
            perr       <= par_en && parity_bad(sh, pbit, par_odd);
            ovr        <= pend && !take;
            pend       <= 1'b1;
          end else if (tick) tcnt <= tcnt + 1'b1;
        end
        default: st <= RX_HUNT;
      endcase
    end
  end

  // R5: a start that is high again at mid-bit goes back to hunting
  p_glitch_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && mid_hit && line) |=> (st == RX_HUNT && !dout_valid));
  // R6: the word strobe lasts a single cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);
  // R7: no parity error can be reported with parity disabled
  p_no_perr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !par_en) |-> !perr);
  // R9: hunting resumes right after the first stop sample
  p_rehunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (st == RX_HUNT && dout_valid));
  // R11: held word and flags move only with the strobe
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> ($stable(dout) && $stable(perr) && $stable(ferr) && $stable(ovr)));
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop_two,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_take,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_overrun
);
  logic tick;

  serial_xcvr_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  serial_xcvr_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en), .par_odd(par_odd),
    .stop_two(stop_two), .din(tx_data), .din_valid(tx_valid),
    .din_ready(tx_ready), .txd(txd)
  );

  serial_xcvr_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en), .par_odd(par_odd),
    .rxd(rxd), .take(rx_take), .dout(rx_data), .dout_valid(rx_valid),
    .perr(rx_par_err), .ferr(rx_frm_err), .ovr(rx_overrun)
  );
endmodule

// File: tb/serial_xcvr_tb_top.sv
`timescale 1ns/1ps
module serial_xcvr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_div = 12'd1;
  logic        par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd;
  logic        rxd = 1'b1;
  logic        rx_take = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_par_err, rx_frm_err, rx_overrun;

  int n_chk = 0;
  int n_err = 0;

  int       got_n = 0;
  logic [7:0] got_d;
  logic     got_pe, got_fe, got_ov;

  always #2.5 clk = ~clk;

  serial_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .par_en(par_en),
    .par_odd(par_odd), .stop_two(stop_two), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_take(rx_take), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_overrun(rx_overrun)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      got_n  = got_n + 1;
      got_d  = rx_data;
      got_pe = rx_par_err;
      got_fe = rx_frm_err;
      got_ov = rx_overrun;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // parity bit expected on the line, from a count of ones
  function automatic bit exp_par(input logic [7:0] b, input bit odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return odd ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  function automatic int bitp();
    return 16 * (int'(baud_div) + 1);
  endfunction

  int cur;
  task automatic wait_to(input int target);
    while (cur < target) begin @(negedge clk); cur++; end
  endtask

  // send one word and decode the line at slot centres
  task automatic tx_frame(input logic [7:0] b);
    int slot_c;
    int s0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R2 ready when idle", tx_ready, 1);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(txd == 1'b0 && tx_ready == 1'b0, "R3 start bit low", txd, 0);
    cur = 0;
    for (int j = 1; j <= 8; j++) begin
      slot_c = (16 * j + 8) * (int'(baud_div) + 1);
      if (j == 4) begin
        tx_data = ~b; tx_valid = 1'b1;
        check(tx_ready == 1'b0, "R2 busy during frame", tx_ready, 0);
      end
      if (j == 5) tx_valid = 1'b0;
      wait_to(slot_c);
      check(txd == b[j-1], "R3 data bit lsb first", txd, b[j-1]);
    end
    s0 = 9;
    if (par_en) begin
      wait_to((16 * 9 + 8) * (int'(baud_div) + 1));
      check(txd == exp_par(b, par_odd), "R4 parity bit", txd, exp_par(b, par_odd));
      s0 = 10;
    end
    wait_to((16 * s0 + 8) * (int'(baud_div) + 1));
    check(txd == 1'b1, "R3 first stop high (R4 no parity slot)", txd, 1);
    wait_to((16 * (s0 + 1) + 8) * (int'(baud_div) + 1));
    if (stop_two)
      check(txd == 1'b1 && tx_ready == 1'b0, "R3 second stop high", tx_ready, 0);
    else
      check(tx_ready == 1'b1 && txd == 1'b1, "R3 idle after one stop", tx_ready, 1);
    while (!tx_ready) @(negedge clk);
  endtask

  // measure the length of a high data bit
  task automatic measure_bit(input logic [11:0] d);
    int len = 0;
    baud_div = d;
    repeat (40) @(negedge clk);
    tx_data = 8'h01; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    while (txd == 1'b0) @(negedge clk);
    while (txd == 1'b1) begin @(negedge clk); len++; end
    check(len == bitp(), "R1 bit length", len, bitp());
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic drive(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // serialize one character onto rxd; nstop stop slots, first one s1v
  task automatic rx_send(input logic [7:0] b, input bit flip, input logic s1v,
                         input int nstop, input int gap);
    int p = bitp();
    drive(1'b0, p);
    for (int i = 0; i < 8; i++) drive(b[i], p);
    if (par_en) drive(exp_par(b, par_odd) ^ flip, p);
    drive(s1v, p);
    for (int i = 1; i < nstop; i++) drive(1'b1, p);
    if (gap > 0) drive(1'b1, gap * p);
  endtask

  task automatic take_word();
    @(negedge clk); rx_take = 1'b1;
    @(negedge clk); rx_take = 1'b0;
  endtask

  task automatic rx_check(input int n0, input logic [7:0] b, input bit pe,
                          input bit fe, input bit ov, input string req);
    check(got_n == n0 + 1, {req, " word count"}, got_n, n0 + 1);
    check(got_d == b, {req, " data"}, got_d, b);
    check(got_pe == pe, {req, " parity flag"}, got_pe, pe);
    check(got_fe == fe, {req, " framing flag"}, got_fe, fe);
    check(got_ov == ov, {req, " overrun flag"}, got_ov, ov);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] pats [4];
    int n0;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready == 1'b1 && txd == 1'b1, "R2 reset idle", txd, 1);
    check(rx_valid == 1'b0, "R6 reset no valid", rx_valid, 0);

    // R1 bit timing at several divisors
    measure_bit(12'd0);
    measure_bit(12'd2);
    measure_bit(12'd5);

    // R3 R4 transmit sweep over all frame shapes
    baud_div = 12'd1;
    for (int c = 0; c < 8; c++) begin
      par_en = c[0]; par_odd = c[1]; stop_two = c[2];
      for (int k = 0; k < 4; k++) tx_frame(pats[k] ^ 8'(c));
    end

    // R6 R7 R8 receive sweep
    baud_div = 12'd3;
    repeat (70) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      par_en = c[0]; par_odd = c[1]; stop_two = c[2];
      for (int k = 0; k < 4; k++) begin
        bit fl = par_en && (k == 2);
        n0 = got_n;
        rx_send(pats[k] ^ 8'(c << 3), fl, 1'b1, stop_two ? 2 : 1, 1);
        rx_check(n0, pats[k] ^ 8'(c << 3), fl, 1'b0, 1'b0, "R6 R7 rx sweep");
        take_word();
      end
    end

    // R8 low first stop bit, then line returns high
    par_en = 1'b0; stop_two = 1'b0;
    n0 = got_n;
    rx_send(8'h5A, 1'b0, 1'b0, 1, 3);
    rx_check(n0, 8'h5A, 1'b0, 1'b1, 1'b0, "R8 framing");
    take_word();

    // R5 short low pulse is dropped; R11 held word unchanged
    n0 = got_n;
    drive(1'b0, 4 * (int'(baud_div) + 1));
    drive(1'b1, 3 * bitp());
    check(got_n == n0, "R5 glitch dropped", got_n, n0);
    check(rx_data == 8'h5A, "R11 word held", rx_data, 8'h5A);
    n0 = got_n;
    rx_send(8'hC3, 1'b0, 1'b1, 1, 1);
    rx_check(n0, 8'hC3, 1'b0, 1'b0, 1'b0, "R5 after glitch");
    take_word();

    // R9 start bit inside the second stop slot
    stop_two = 1'b1; par_en = 1'b1; par_odd = 1'b1;
    n0 = got_n;
    rx_send(8'h81, 1'b0, 1'b1, 1, 0);
    rx_check(n0, 8'h81, 1'b0, 1'b0, 1'b0, "R9 first char");
    rx_take = 1'b1;
    n0 = got_n;
    rx_send(8'h7E, 1'b0, 1'b1, 2, 1);
    rx_take = 1'b0;
    rx_check(n0, 8'h7E, 1'b0, 1'b0, 1'b0, "R9 second char");
    take_word();

    // R10 overrun when a word is not taken
    stop_two = 1'b0; par_en = 1'b0;
    rx_send(8'h11, 1'b0, 1'b1, 1, 1);
    n0 = got_n;
    rx_send(8'h22, 1'b0, 1'b1, 1, 1);
    rx_check(n0, 8'h22, 1'b0, 1'b0, 1'b1, "R10 overrun set");
    take_word();
    n0 = got_n;
    rx_send(8'h33, 1'b0, 1'b1, 1, 1);
    rx_check(n0, 8'h33, 1'b0, 1'b0, 1'b0, "R10 overrun clear");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule